// File: doc/BRIEF.md
# Polled Byte-Port Device Controller

This block is a device controller that software drives through a word-addressed register bus. It has a command register, a status register and a bank of data registers. Software polls the status register until the controller is idle, loads the data registers, then writes a command code. The controller goes busy and runs a transfer against an external byte-wide port. An outbound command streams the data bank to the port under a valid/ready handshake. An inbound command fills the bank from the port.

When the last byte has moved, the controller leaves busy and raises done. Software reads the result and then clears done with a status write, which returns the controller to idle. Two status flags, busy and done, form a four-state code. The combination with both flags set is never produced. A 4-bit error field records a rejected command or an unknown opcode.

Top module: `pdev_ctrl`

## Requirements
- R1: Status register layout: bit 0 = busy, bit 1 = done, bits 7:4 = error code, bits 3:2 read as 0. busy and done are never both 1.
- R2: Address map: offset 0 is the command register, offset 1 is status, offsets 2 to 2+N_DATA-1 are data registers 0 to N_DATA-1. A read of any other offset returns 0, and a write to any other offset changes nothing.
- R3: A command write is accepted only when busy=0 and done=0. For a known opcode, acceptance makes status read busy=1 from the next cycle, and every accepted command clears the error field to 0. The command register reads back the last accepted code.
- R4: A command write while busy or done changes neither the phase nor the command register. It sets the error field to 1, which stays until the next accepted command.
- R5: Opcode 0x01 sends data registers 0 to N_DATA-1, in that order, one byte per cycle in which tx_valid and tx_ready are both 1. tx_data stays stable while tx_valid=1 and tx_ready=0.
- R6: Opcode 0x02 holds rx_ready=1 and stores each byte accepted with rx_valid=1 into data registers 0 to N_DATA-1, in order.
- R7: On the clock edge that completes the last handshake, busy clears and done sets together. With an always-ready sink, an outbound transfer accepted at edge k shows done after edge k+N_DATA.
- R8: A status write with bit 1 = 1 while done returns the controller to idle. A status write with bit 1 = 0 has no effect, and the error field is not changed by a status write.
- R9: Any other opcode is accepted without going busy. The status register reads done=1 and error=2 from the next cycle, and no port activity takes place.
- R10: Bus writes to data registers are ignored while busy.
- R11: After reset, status reads 0, all data registers read 0, and tx_valid and rx_ready are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write enable for the access |
| bus_addr | input | AW | Word offset |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for bus_addr (combinational) |
| tx_valid | output | 1 | Outbound byte valid |
| tx_data | output | DW | Outbound byte |
| tx_ready | input | 1 | Device accepts outbound byte |
| rx_valid | input | 1 | Inbound byte valid |
| rx_data | input | DW | Inbound byte |
| rx_ready | output | 1 | Controller accepts inbound byte |

## Verification
The bench uses the default parameters: N_DATA=8 and DW=8, which give a 4-bit offset. Offsets 10 to 15 are then unmapped, so R2 can be exercised on real addresses. Eight handshakes per transfer leave enough cycles to issue a rejected command and an ignored data write in the middle of a transfer, even when the port is always ready. The 3-bit transfer index reaches its final value, so the exact cycle of completion can be checked.

// File: rtl/pdev_pkg.sv
package pdev_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_SEND = 2'd1,
    PH_RECV = 2'd2,
    PH_DONE = 2'd3
  } phase_e;

  localparam int ERR_W     = 4;
  localparam int OFS_CMD   = 0;
  localparam int OFS_STAT  = 1;
  localparam int OFS_DATA  = 2;
  localparam int BIT_BUSY  = 0;
  localparam int BIT_DONE  = 1;

  localparam logic [7:0] OP_SEND = 8'h01;
  localparam logic [7:0] OP_RECV = 8'h02;

  localparam logic [ERR_W-1:0] ERR_NONE   = 4'd0;
  localparam logic [ERR_W-1:0] ERR_REJECT = 4'd1;
  localparam logic [ERR_W-1:0] ERR_BADOP  = 4'd2;
endpackage

// File: rtl/pdev_rst_sync.sv
module pdev_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_n;

  always_comb begin
    chain_n = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_n;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/pdev_bus_dec.sv
module pdev_bus_dec import pdev_pkg::*; #(
  parameter int N_DATA = 8,
  parameter int DW     = 8,
  parameter int AW     = 4
) (
  input  logic                         bus_sel,
  input  logic                         bus_we,
  input  logic [AW-1:0]                bus_addr,
  input  logic [DW-1:0]                cmd_q,
  input  logic [DW-1:0]                status,
  input  logic [N_DATA-1:0][DW-1:0]    data_q,
  output logic                         cmd_wr,
  output logic                         stat_wr,
  output logic [N_DATA-1:0]            data_wr,
  output logic [DW-1:0]                bus_rdata
);
  logic wr_cyc;

  assign wr_cyc  = bus_sel & bus_we;
  assign cmd_wr  = wr_cyc & (bus_addr == AW'(OFS_CMD));
  assign stat_wr = wr_cyc & (bus_addr == AW'(OFS_STAT));

  for (genvar g = 0; g < N_DATA; g++) begin : g_wdec
    assign data_wr[g] = wr_cyc & (bus_addr == AW'(OFS_DATA + g));
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == AW'(OFS_CMD))  bus_rdata = cmd_q;
    if (bus_addr == AW'(OFS_STAT)) bus_rdata = status;
    for (int i = 0; i < N_DATA; i++) begin
      if (bus_addr == AW'(OFS_DATA + i)) bus_rdata = data_q[i];
    end
  end
endmodule

// File: rtl/pdev_data_bank.sv
module pdev_data_bank #(
  parameter int N_DATA = 8,
  parameter int DW     = 8,
  parameter int IW     = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_DATA-1:0]         bus_en,
  input  logic [DW-1:0]             bus_wdata,
  input  logic                      cap_en,
  input  logic [IW-1:0]             cap_idx,
  input  logic [DW-1:0]             cap_data,
  output logic [N_DATA-1:0][DW-1:0] data_q
);
  for (genvar g = 0; g < N_DATA; g++) begin : g_reg
    logic [DW-1:0] reg_q;
    logic [DW-1:0] reg_n;
    logic          reg_en;

    always_comb begin
      reg_en = bus_en[g] | (cap_en & (cap_idx == IW'(g)));
      reg_n  = bus_en[g] ? bus_wdata : cap_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      reg_q <= '0;
      else if (reg_en) reg_q <= reg_n;
    end

    assign data_q[g] = reg_q;
  end
endmodule

// File: rtl/pdev_seq.sv
module pdev_seq import pdev_pkg::*; #(
  parameter int N_DATA = 8,
  parameter int DW     = 8,
  parameter int IW     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic [DW-1:0]    cmd_code,
  input  logic             clr_done,
  input  logic             tx_ready,
  input  logic             rx_valid,
  output logic             busy,
  output logic             done,
  output logic [ERR_W-1:0] err,
  output logic [DW-1:0]    cmd_q,
  output logic [IW-1:0]    idx,
  output logic             tx_valid,
  output logic             rx_ready,
  output logic             cap_en
);
  localparam logic [IW-1:0] IDX_LAST = IW'(N_DATA - 1);

  phase_e           ph_q, ph_n;
  logic [IW-1:0]    idx_q, idx_n;
  logic [ERR_W-1:0] err_q, err_n;
  logic [DW-1:0]    cmd_n;
  logic             cmd_en;
  logic             accept;
  logic             step;

  assign accept = cmd_wr & (ph_q == PH_IDLE);
  assign step   = ((ph_q == PH_SEND) & tx_ready) | ((ph_q == PH_RECV) & rx_valid);

  always_comb begin
    ph_n   = ph_q;
    idx_n  = idx_q;
    err_n  = err_q;
    cmd_n  = cmd_q;
    cmd_en = 1'b0;
    if (accept) begin
      cmd_en = 1'b1;
      cmd_n  = cmd_code;
      idx_n  = '0;
      if (cmd_code == DW'(OP_SEND)) begin
        ph_n  = PH_SEND;
        err_n = ERR_NONE;
      end else if (cmd_code == DW'(OP_RECV)) begin
        ph_n  = PH_RECV;
        err_n = ERR_NONE;
      end else begin
        ph_n  = PH_DONE;
        err_n = ERR_BADOP;
      end
    end else if (cmd_wr) begin
      err_n = ERR_REJECT;
    end
    if (step) begin
      if (idx_q == IDX_LAST) begin
        ph_n  = PH_DONE;
        idx_n = '0;
      end else begin
        idx_n = idx_q + IW'(1);
      end
    end
    if ((ph_q == PH_DONE) && clr_done) ph_n = PH_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      idx_q <= '0;
      err_q <= ERR_NONE;
      cmd_q <= '0;
    end else begin
      ph_q  <= ph_n;
      idx_q <= idx_n;
      err_q <= err_n;
      if (cmd_en) cmd_q <= cmd_n;
    end
  end

  assign busy     = (ph_q == PH_SEND) | (ph_q == PH_RECV);
  assign done     = (ph_q == PH_DONE);
  assign err      = err_q;
  assign idx      = idx_q;
  assign tx_valid = (ph_q == PH_SEND);
  assign rx_ready = (ph_q == PH_RECV);
  assign cap_en   = (ph_q == PH_RECV) & rx_valid;
endmodule

// File: rtl/pdev_ctrl.sv
module pdev_ctrl import pdev_pkg::*; #(
  parameter  int N_DATA = 8,
  parameter  int DW     = 8,
  localparam int AW     = $clog2(N_DATA + 2),
  localparam int IW     = (N_DATA > 1) ? $clog2(N_DATA) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data,
  input  logic          tx_ready,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  output logic          rx_ready
);
  logic                      srst_n;
  logic                      cmd_wr;
  logic                      stat_wr;
  logic                      clr_done;
  logic [N_DATA-1:0]         data_wr;
  logic [N_DATA-1:0]         bank_en;
  logic                      busy;
  logic                      done;
  logic [ERR_W-1:0]          err;
  logic [DW-1:0]             cmd_q;
  logic [IW-1:0]             idx;
  logic                      cap_en;
  logic [N_DATA-1:0][DW-1:0] data_q;
  logic [DW-1:0]             status;

  pdev_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  pdev_bus_dec #(.N_DATA(N_DATA), .DW(DW), .AW(AW)) u_dec (
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .cmd_q     (cmd_q),
    .status    (status),
    .data_q    (data_q),
    .cmd_wr    (cmd_wr),
    .stat_wr   (stat_wr),
    .data_wr   (data_wr),
    .bus_rdata (bus_rdata)
  );

  assign clr_done = stat_wr & bus_wdata[BIT_DONE];
  assign bank_en  = data_wr & {N_DATA{~busy}};

  pdev_seq #(.N_DATA(N_DATA), .DW(DW), .IW(IW)) u_seq (
    .clk      (clk),
    .rst_n    (srst_n),
    .cmd_wr   (cmd_wr),
    .cmd_code (bus_wdata),
    .clr_done (clr_done),
    .tx_ready (tx_ready),
    .rx_valid (rx_valid),
    .busy     (busy),
    .done     (done),
    .err      (err),
    .cmd_q    (cmd_q),
    .idx      (idx),
    .tx_valid (tx_valid),
    .rx_ready (rx_ready),
    .cap_en   (cap_en)
  );

  pdev_data_bank #(.N_DATA(N_DATA), .DW(DW), .IW(IW)) u_bank (
    .clk       (clk),
    .rst_n     (srst_n),
    .bus_en    (bank_en),
    .bus_wdata (bus_wdata),
    .cap_en    (cap_en),
    .cap_idx   (idx),
    .cap_data  (rx_data),
    .data_q    (data_q)
  );

  always_comb begin
    status                = '0;
    status[BIT_BUSY]      = busy;
    status[BIT_DONE]      = done;
    status[DW-1 -: ERR_W] = err;
  end

  assign tx_data = data_q[idx];
endmodule

// File: rtl/pdev_chk.sv
module pdev_chk import pdev_pkg::*; #(
  parameter int DW = 8
) (
  input logic             clk,
  input logic             srst_n,
  input logic             busy,
  input logic             done,
  input logic [ERR_W-1:0] err,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic [DW-1:0]    tx_data,
  input logic             rx_ready,
  input logic             cmd_wr,
  input logic             clr_done
);
  // R1
  a_r1_never_both: assert property (@(posedge clk) disable iff (!srst_n)
    !(busy && done));

  // R3
  a_r3_accept_idle: assert property (@(posedge clk) disable iff (!srst_n)
    (cmd_wr && !busy && !done) |=> ((busy || done) && (err != ERR_REJECT)));

  // R4
  a_r4_reject_sticky: assert property (@(posedge clk) disable iff (!srst_n)
    (cmd_wr && (busy || done)) |=> (err == ERR_REJECT));

  // R5
  a_r5_tx_hold: assert property (@(posedge clk) disable iff (!srst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  // R6
  a_r6_rx_in_busy: assert property (@(posedge clk) disable iff (!srst_n)
    rx_ready |-> (busy && !tx_valid));

  // R7
  a_r7_busy_ends_done: assert property (@(posedge clk) disable iff (!srst_n)
    $fell(busy) |-> done);

  // R8
  a_r8_done_holds: assert property (@(posedge clk) disable iff (!srst_n)
    (done && !clr_done) |=> done);
endmodule

bind pdev_ctrl pdev_chk #(.DW(DW)) u_chk (
  .clk      (clk),
  .srst_n   (srst_n),
  .busy     (busy),
  .done     (done),
  .err      (err),
  .tx_valid (tx_valid),
  .tx_ready (tx_ready),
  .tx_data  (tx_data),
  .rx_ready (rx_ready),
  .cmd_wr   (cmd_wr),
  .clr_done (clr_done)
);

// File: tb/test_pdev_ctrl.sv
`timescale 1ns/1ps
module test_pdev_ctrl;
  localparam int N  = 8;
  localparam int DW = 8;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_sel, bus_we;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;
  logic          tx_valid, tx_ready;
  logic [DW-1:0] tx_data;
  logic          rx_valid, rx_ready;
  logic [DW-1:0] rx_data;

  int total = 0;
  int bad   = 0;
  logic [7:0] model [N];
  logic [7:0] cap   [N];
  logic [7:0] src   [N];
  int  cap_n = 0;
  int  src_i = 0;
  bit  sink_on = 0, sink_full = 0, src_on = 0;
  logic [7:0] rd;
  int unsigned seed_use;

  always #2 clk = ~clk;

  pdev_ctrl #(.N_DATA(N), .DW(DW)) i_pdev_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready)
  );

  function automatic logic [7:0] st_exp(bit b, bit d, logic [3:0] e);
    return {e, 2'b00, d, b};
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bw(int a, logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic br(int a, output logic [7:0] d);
    bus_addr = AW'(a);
    #1 d = bus_rdata;
  endtask

  task automatic wait_done();
    int n = 0;
    logic [7:0] s;
    do begin
      @(negedge clk);
      br(1, s);
      n++;
      total++;
      if (s[0] && s[1]) begin
        bad++;
        $display("FAIL R1 actual=%h expected=busy/done not both", s);
      end
    end while (!s[1] && n < 2000);
  endtask

  // device sink
  always @(negedge clk) begin
    tx_ready = sink_on ? (sink_full ? 1'b1 : 1'($urandom_range(0, 1))) : 1'b0;
    #1;
    if (tx_valid && tx_ready) begin
      if (cap_n < N) cap[cap_n] = tx_data;
      cap_n++;
    end
  end

  // device source
  always @(negedge clk) begin
    rx_valid = src_on ? ($urandom_range(0, 3) != 0) : 1'b0;
    rx_data  = (src_i < N) ? src[src_i] : 8'h00;
    #1;
    if (rx_valid && rx_ready) src_i++;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    seed_use = $urandom(32'd7719);
    rst_n = 1'b0; bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    tx_ready = 1'b0; rx_valid = 1'b0; rx_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 reset state
    br(1, rd); check("R11 status", rd, 8'h00);
    check("R11 tx_valid", {7'd0, tx_valid}, 8'h00);
    check("R11 rx_ready", {7'd0, rx_ready}, 8'h00);
    for (int i = 0; i < N; i++) begin
      br(2 + i, rd); check("R11 data", rd, 8'h00);
    end

    // R2 unmapped offsets
    for (int a = 2 + N; a < 16; a++) begin
      bw(a, 8'($urandom));
      br(a, rd); check("R2 unmapped read", rd, 8'h00);
    end
    br(1, rd); check("R2 status untouched", rd, 8'h00);
    br(2, rd); check("R2 data untouched", rd, 8'h00);

    // R9 unknown opcode, R4 reject while done, R8 clear
    bw(0, 8'h7E);
    br(1, rd); check("R9 bad opcode status", rd, st_exp(0, 1, 4'd2));
    check("R9 no tx", {7'd0, tx_valid}, 8'h00);
    br(0, rd); check("R3 cmd readback", rd, 8'h7E);
    bw(0, 8'h01);
    br(1, rd); check("R4 reject when done", rd, st_exp(0, 1, 4'd1));
    br(0, rd); check("R4 cmd unchanged", rd, 8'h7E);
    bw(1, 8'hFD);
    br(1, rd); check("R8 bit1 clear no effect", rd, st_exp(0, 1, 4'd1));
    bw(1, 8'h02);
    br(1, rd); check("R8 clear to idle", rd, st_exp(0, 0, 4'd1));

    // R7 exact completion cycle with always-ready sink
    for (int i = 0; i < N; i++) begin
      model[i] = 8'(i * 17 + 3);
      bw(2 + i, model[i]);
    end
    cap_n = 0; sink_on = 1; sink_full = 1;
    bw(0, 8'h01);
    br(1, rd); check("R3 busy after accept", rd, st_exp(1, 0, 4'd0));
    repeat (N - 1) @(negedge clk);
    br(1, rd); check("R7 busy before last edge", rd, st_exp(1, 0, 4'd0));
    @(negedge clk);
    br(1, rd); check("R7 done after last edge", rd, st_exp(0, 1, 4'd0));
    check("R5 count", 8'(cap_n), 8'(N));
    for (int i = 0; i < N; i++) check("R5 order", cap[i], model[i]);
    sink_on = 0; sink_full = 0;
    bw(1, 8'h02);

    // random rounds
    for (int r = 0; r < 8; r++) begin
      if ((r % 2) == 0) begin
        for (int i = 0; i < N; i++) begin
          model[i] = 8'($urandom);
          bw(2 + i, model[i]);
        end
        cap_n = 0; sink_on = 1;
        bw(0, 8'h01);
        br(1, rd); check("R3 accept send", rd, st_exp(1, 0, 4'd0));
        bw(0, 8'h02);
        br(1, rd); check("R4 reject busy", rd, st_exp(1, 0, 4'd1));
        bw(2, ~model[0]);
        wait_done();
        br(1, rd); check("R4 sticky at done", rd, st_exp(0, 1, 4'd1));
        check("R5 count", 8'(cap_n), 8'(N));
        for (int i = 0; i < N; i++) check("R5 data", cap[i], model[i]);
        br(2, rd); check("R10 write ignored in busy", rd, model[0]);
        sink_on = 0;
        bw(1, 8'h02);
        br(1, rd); check("R8 idle err kept", rd, st_exp(0, 0, 4'd1));
      end else begin
        for (int i = 0; i < N; i++) src[i] = 8'($urandom);
        src_i = 0; src_on = 1;
        bw(0, 8'h02);
        br(1, rd); check("R3 accept recv clears err", rd, st_exp(1, 0, 4'd0));
        wait_done();
        src_on = 0;
        br(1, rd); check("R6 done", rd, st_exp(0, 1, 4'd0));
        for (int i = 0; i < N; i++) begin
          br(2 + i, rd); check("R6 captured", rd, src[i]);
          model[i] = src[i];
        end
        bw(1, 8'h02);
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule